// File: doc/BRIEF.md
# External Memory Table-Write Sequencer

This block runs the bus sequence that stores one 16-bit word from a small controller core into external program memory. The core supplies the table pointer, the two-byte table latch, the address of the next instruction fetch, a start pulse and a post-increment flag. The block then runs two instruction cycles of four phases each on a multiplexed address/data bus. The first cycle is an ordinary fetch of the next instruction. In the second cycle the bus carries the table pointer as an address and then the latched word as write data.

The bus leaves the block as a value plus a drive enable, so the pad ring can build the tristate buffer. The block also produces the address latch enable, the active-low output enable and the active-low write strobe. While the sequence runs, the block keeps the core from taking an interrupt. In the last phase it acknowledges an interrupt that is pending, so the core takes that interrupt only after the write has finished. The updated pointer appears at the output one clock after the final phase.

Top module: `tw_table_write`

## Requirements
- R1: After asynchronous active-low reset, the bus drive enable is 0, oe_n and wr_n are 1, ale and busy are 0, and the pointer output is 0.
- R2: A start pulse that is sampled while idle makes busy rise on the next clock. Busy then stays high for exactly 8 clocks, which is two cycles of four phases (steps 0 to 7), and falls afterwards.
- R3: In steps 0 and 1 the bus is driven with the fetch address, and ale is 1 in step 0 only. In steps 2 and 3 the bus is released and oe_n is 0.
- R4: In steps 4 and 5 the bus is driven with the table pointer, and ale is 1 in step 4 only. In steps 6 and 7 the bus is driven with the latched data word.
- R5: oe_n stays 1 for all of steps 4 to 7. wr_n is 0 in step 6 only, so the data is stable on both edges of the strobe.
- R6: One clock after step 7, the pointer output becomes the captured table pointer plus 1 (modulo 2^16) if the increment flag was set, or the captured pointer unchanged if it was clear. The pointer output changes at no other time.
- R7: The interrupt hold output is 1 during every busy clock. A pending interrupt, whether present at start or arriving during the sequence, does not shorten it.
- R8: The interrupt acknowledge is 1 in step 7 exactly when an interrupt is pending, and 0 at all other times.
- R9: A start pulse sampled while busy, including in step 7, is ignored. The captured pointer and data are not changed, and no new sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock request to begin a table write |
| inc_i | input | 1 | Post-increment the pointer when 1 |
| pc_next_i | input | 16 | Address of the next instruction fetch |
| tbl_ptr_i | input | 16 | Table pointer to write to |
| tbl_data_i | input | 16 | Table latch word, high and low bytes |
| irq_pending_i | input | 1 | An interrupt is waiting to be taken |
| bus_o | output | 16 | Value for the multiplexed address/data bus |
| bus_oe_o | output | 1 | Drive enable for the bus pads |
| ale_o | output | 1 | Address latch enable |
| oe_n_o | output | 1 | Output enable, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| busy_o | output | 1 | Sequence in progress |
| irq_hold_o | output | 1 | Interrupt servicing held off |
| irq_ack_o | output | 1 | Acknowledge of the pending interrupt at completion |
| ptr_o | output | 16 | Table pointer after the write |

## Verification
Three things can fall in the final phase together: completion with its interrupt acknowledge and pointer update, and a new start request. The bench provokes this by keeping an interrupt pending, setting the increment flag and pulsing start again in step 7 with a different pointer. It then expects the acknowledge in step 7 and the incremented original pointer one clock later. It also expects busy to be low and the memory model to hold the original word, with no second sequence. Other runs raise the interrupt halfway through and restart in step 2, and every phase's bus value and strobes are compared against the step table.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    TW_IDLE  = 2'd0,
    TW_FETCH = 2'd1,
    TW_WRITE = 2'd2
  } tw_state_e;
endpackage

// File: rtl/tw_phase_seq.sv
module tw_phase_seq
  import tw_pkg::*;
#(
  parameter int PHASES = 4,
  parameter int PW     = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output tw_state_e     state_o,
  output logic [PW-1:0] phase_o,
  output logic          accept_o,
  output logic          done_o
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  tw_state_e     state_q;
  logic [PW-1:0] phase_q;

  assign accept_o = start_i && (state_q == TW_IDLE);
  assign done_o   = (state_q == TW_WRITE) && (phase_q == LAST);
  assign state_o  = state_q;
  assign phase_o  = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TW_IDLE;
      phase_q <= '0;
    end else if (state_q == TW_IDLE) begin
      if (accept_o) begin
        state_q <= TW_FETCH;
        phase_q <= '0;
      end
    end else if (phase_q == LAST) begin
      phase_q <= '0;
      state_q <= (state_q == TW_FETCH) ? TW_WRITE : TW_IDLE;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tw_ptr_unit.sv
module tw_ptr_unit #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          done_i,
  input  logic          inc_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [AW-1:0] ptr_o
);
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic inc);
    return p + {{(AW-1){1'b0}}, inc};
  endfunction

  logic inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o   <= '0;
      addr_o <= '0;
      data_o <= '0;
      inc_q  <= 1'b0;
      ptr_o  <= '0;
    end else begin
      if (accept_i) begin
        pc_o   <= pc_i;
        addr_o <= ptr_i;
        data_o <= data_i;
        inc_q  <= inc_i;
      end
      if (done_i) ptr_o <= bump(addr_o, inc_q);
    end
  end
endmodule

// File: rtl/tw_bus_drive.sv
module tw_bus_drive
  import tw_pkg::*;
#(
  parameter int AW     = 16,
  parameter int PHASES = 4,
  parameter int PW     = $clog2(PHASES)
) (
  input  tw_state_e     state_i,
  input  logic [PW-1:0] phase_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          ale_o,
  output logic          oe_n_o,
  output logic          wr_n_o
);
  localparam logic [PW-1:0] HALF = PW'(PHASES / 2);

  function automatic logic in_addr_half(input logic [PW-1:0] ph);
    return ph < HALF;
  endfunction

  always_comb begin
    bus_o    = '0;
    bus_oe_o = 1'b0;
    ale_o    = 1'b0;
    oe_n_o   = 1'b1;
    wr_n_o   = 1'b1;
    case (state_i)
      TW_FETCH: begin
        ale_o = (phase_i == '0);
        if (in_addr_half(phase_i)) begin
          bus_oe_o = 1'b1;
          bus_o    = pc_i;
        end else begin
          oe_n_o = 1'b0;
        end
      end
      TW_WRITE: begin
        ale_o    = (phase_i == '0);
        bus_oe_o = 1'b1;
        bus_o    = in_addr_half(phase_i) ? addr_i : data_i;
        wr_n_o   = !(phase_i == HALF);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tw_table_write.sv
module tw_table_write
  import tw_pkg::*;
#(
  parameter int AW     = 16,
  parameter int PHASES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          inc_i,
  input  logic [AW-1:0] pc_next_i,
  input  logic [AW-1:0] tbl_ptr_i,
  input  logic [AW-1:0] tbl_data_i,
  input  logic          irq_pending_i,
  output logic [AW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          ale_o,
  output logic          oe_n_o,
  output logic          wr_n_o,
  output logic          busy_o,
  output logic          irq_hold_o,
  output logic          irq_ack_o,
  output logic [AW-1:0] ptr_o
);
  localparam int PW = $clog2(PHASES);

  tw_state_e     state;
  logic [PW-1:0] phase;
  logic          accept_w, done_w, in_write;
  logic [AW-1:0] pc_q, addr_q, data_q;

  tw_phase_seq #(.PHASES(PHASES), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .state_o(state), .phase_o(phase), .accept_o(accept_w), .done_o(done_w)
  );

  tw_ptr_unit #(.AW(AW), .DW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .done_i(done_w),
    .inc_i(inc_i), .pc_i(pc_next_i), .ptr_i(tbl_ptr_i), .data_i(tbl_data_i),
    .pc_o(pc_q), .addr_o(addr_q), .data_o(data_q), .ptr_o(ptr_o)
  );

  tw_bus_drive #(.AW(AW), .PHASES(PHASES), .PW(PW)) u_bus (
    .state_i(state), .phase_i(phase), .pc_i(pc_q), .addr_i(addr_q),
    .data_i(data_q), .bus_o(bus_o), .bus_oe_o(bus_oe_o), .ale_o(ale_o),
    .oe_n_o(oe_n_o), .wr_n_o(wr_n_o)
  );

  assign in_write   = (state == TW_WRITE);
  assign busy_o     = (state != TW_IDLE);
  assign irq_hold_o = busy_o;
  assign irq_ack_o  = done_w && irq_pending_i;
endmodule

// File: rtl/tw_table_write_chk.sv
module tw_table_write_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          ale_o,
  input logic          oe_n_o,
  input logic          wr_n_o,
  input logic          bus_oe_o,
  input logic          irq_ack_o,
  input logic          irq_pending_i,
  input logic [AW-1:0] ptr_o,
  input logic          in_write,
  input logic          done_w
);
  // R5: strobe only in write cycle, never with output enable or ale
  a_r5_strobe_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> (in_write && oe_n_o && !ale_o));
  // R5: output enable inactive throughout the write cycle
  a_r5_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_write |-> oe_n_o);
  // R3: an address strobe implies a driven bus
  a_r3_ale_driven: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> bus_oe_o);
  // R4: data driven while strobing
  a_r4_data_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> bus_oe_o);
  // R2: busy ends only after completion
  a_r2_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_w));
  // R9: completion is followed by idle even if start is seen then
  a_r9_no_rerun: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> !busy_o);
  // R6: pointer output moves only right after completion
  a_r6_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_o) |-> $past(done_w));
  // R8: acknowledge only at completion with a pending request
  a_r8_ack_when: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> (done_w && irq_pending_i));
endmodule

bind tw_table_write tw_table_write_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .ale_o(ale_o),
  .oe_n_o(oe_n_o), .wr_n_o(wr_n_o), .bus_oe_o(bus_oe_o),
  .irq_ack_o(irq_ack_o), .irq_pending_i(irq_pending_i), .ptr_o(ptr_o),
  .in_write(in_write), .done_w(done_w)
);

// File: tb/tb_tw_table_write.sv
module tb_tw_table_write;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, inc_i = 1'b0, irq_pending_i = 1'b0;
  logic [15:0] pc_next_i = '0, tbl_ptr_i = '0, tbl_data_i = '0;
  logic [15:0] bus_o, ptr_o;
  logic        bus_oe_o, ale_o, oe_n_o, wr_n_o, busy_o, irq_hold_o, irq_ack_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] mem [logic [15:0]];
  logic [15:0] lat_addr = '0;
  logic [15:0] cur_ptr = '0;

  always #2 clk = ~clk;

  tw_table_write dut (.*);

  // memory model: latch address on ale fall, store on strobe rise
  always @(negedge ale_o) lat_addr = bus_o;
  always @(posedge wr_n_o) if (rst_n) mem[lat_addr] = bus_o;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // irq_at / restart_at: step index (0..7) or -1; irq_at == 0 means pending at start
  task automatic run_seq(input logic [15:0] pc, input logic [15:0] ptr, input logic [15:0] dat,
                         input bit inc, input int irq_at, input int restart_at);
    logic [15:0] exp_ptr;
    @(negedge clk);
    pc_next_i = pc; tbl_ptr_i = ptr; tbl_data_i = dat; inc_i = inc;
    irq_pending_i = (irq_at == 0);
    start_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      start_i = (i == restart_at);
      if (i == restart_at) begin tbl_ptr_i = ~ptr; tbl_data_i = ~dat; inc_i = ~inc; end
      if (irq_at > 0 && i == irq_at) irq_pending_i = 1'b1;
      #1;
      chk(busy_o === 1'b1, "R2 busy", busy_o, 1);
      chk(irq_hold_o === 1'b1, "R7 hold", irq_hold_o, 1);
      chk(ale_o === (i == 0 || i == 4), "R3/R4 ale", ale_o, (i == 0 || i == 4));
      chk(bus_oe_o === !(i == 2 || i == 3), "R3 bus enable", bus_oe_o, !(i == 2 || i == 3));
      if (i < 2)       chk(bus_o === pc,  "R3 fetch addr", bus_o, pc);
      else if (i == 4 || i == 5) chk(bus_o === ptr, "R4 table addr", bus_o, ptr);
      else if (i >= 6) chk(bus_o === dat, "R4 data", bus_o, dat);
      chk(oe_n_o === !(i == 2 || i == 3), "R5 oe_n", oe_n_o, !(i == 2 || i == 3));
      chk(wr_n_o === !(i == 6), "R5 wr_n", wr_n_o, !(i == 6));
      chk(irq_ack_o === (i == 7 && irq_pending_i), "R8 ack", irq_ack_o, (i == 7 && irq_pending_i));
      chk(ptr_o === cur_ptr, "R6 ptr steady", ptr_o, cur_ptr);
    end
    @(negedge clk);
    start_i = 1'b0; irq_pending_i = 1'b0;
    #1;
    exp_ptr = ptr + {15'd0, inc};
    chk(busy_o === 1'b0, "R2/R9 idle after 8", busy_o, 0);
    chk(ptr_o === exp_ptr, "R6 pointer update", ptr_o, exp_ptr);
    chk(mem[ptr] === dat, "R9/R4 stored word", mem[ptr], dat);
    chk(irq_ack_o === 1'b0, "R8 ack off", irq_ack_o, 0);
    cur_ptr = exp_ptr;
    repeat (2) @(negedge clk);
    chk(busy_o === 1'b0 && bus_oe_o === 1'b0, "R9 no rerun", {busy_o, bus_oe_o}, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(bus_oe_o === 1'b0, "R1 bus released", bus_oe_o, 0);
    chk(oe_n_o === 1'b1 && wr_n_o === 1'b1, "R1 strobes", {oe_n_o, wr_n_o}, 2'b11);
    chk(ale_o === 1'b0 && busy_o === 1'b0, "R1 ale busy", {ale_o, busy_o}, 0);
    chk(ptr_o === 16'h0, "R1 pointer", ptr_o, 0);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_seq(16'h0101, 16'h1234, 16'hBEEF, 1'b0, -1, -1);  // R6 no increment
    run_seq(16'h0202, 16'h2000, 16'hA55A, 1'b1, -1, -1);  // R6 increment
    run_seq(16'h0303, 16'hFFFF, 16'h0F0F, 1'b1, -1, -1);  // R6 wrap
    run_seq(16'h0404, 16'h0040, 16'h1111, 1'b0, 0, -1);   // R7 pending at start
    run_seq(16'h0505, 16'h0050, 16'h2222, 1'b1, 3, -1);   // R7 arrives mid
    run_seq(16'h0606, 16'h0060, 16'h3333, 1'b0, -1, 2);   // R9 restart mid
    run_seq(16'h0707, 16'h0070, 16'h4444, 1'b1, 0, 7);    // R8 R6 R9 collide at end
    summary();
  end
endmodule